// File: doc/BRIEF.md
# Two-Bank Interrupt Steering Controller

This block gathers forty level-sensitive interrupt lines into two 32-bit pending banks. Each enabled, pending source is sent to one of two processor outputs. A steering bit per source picks the output: set means the fast-interrupt output `fiq_o`, clear means the normal-interrupt output `irq_o`. A third output, `wake_o`, asks a halted core to resume. An idle-control bit decides whether masked pending sources count as wake causes. Software uses a simple 32-bit port with an 8-bit byte address. Writes happen on the clock edge. Reads are combinational from the current address.

The wake output is driven by a three-state machine:

- `ST_RUN`: the core is running. `wake_o` is low.
- `ST_HALT_WAIT`: the core is halted and no wake cause is present.
- `ST_WAKE`: the core is halted and a wake cause is present. `wake_o` is high.

The machine has these transitions:

- `go_run`: any state moves to `ST_RUN` when `halted_i` is low.
- `go_wake`: any state moves to `ST_WAKE` when `halted_i` is high and a cause exists.
- `go_wait`: any state moves to `ST_HALT_WAIT` when `halted_i` is high and no cause exists.

The highest-priority lookup is done by a separate block. Its result enters through `top_result_i` and is only read back through this port.

Top module: `irq_steer_ctrl`

## Requirements
- R1: Source n, for n below 32, is bit n of bank 0. Source n from 32 to 39 is bit n-32 of bank 1. Raw pending reads at offset 0x10 for bank 0 and 0xAC for bank 1.
- R2: A pending bit equals the level its line had at the previous clock edge. When the line falls, the bit clears; nothing is latched.
- R3: `fiq_o` is a register. It is set when any bank has a bit where pending, mask and steer are all 1. It reacts two edges after a line change and one edge after a mask or steer write.
- R4: `irq_o` is a register with the same timing as `fiq_o`. It is set when any bank has a bit where pending and mask are 1 and steer is 0.
- R5: The views at 0x00/0x9C return pending&mask&~steer, and the views at 0x0C/0xA8 return pending&mask&steer. They are read-only: writes to them, and to 0x10/0xAC, change no state.
- R6: The control register is at 0x14, and bit 0 is the idle mode. When it is 0, any pending source is a wake cause, masked or not. When it is 1, only enabled pending sources are. A read returns bit 0 in bit 0 and zeros elsewhere.
- R7: `wake_o` is low whenever `halted_i` was low at the last edge. While halted, it follows the wake cause one edge later, through states `ST_RUN`, `ST_HALT_WAIT` and `ST_WAKE`.
- R8: The priority registers sit at 0x1C + 4i for sources 0 to 31 and at 0xB0 + 4(i-32) for sources 32 to 39. They keep only bit 31 and bits 5:0 of a write; all other bits read as 0.
- R9: After reset, every pending, mask, steer, control and priority register reads 0, and all three outputs are low.
- R10: Reads return 0 from any unmapped offset: one above 0xCC or not word aligned. Writes to such an offset are ignored.
- R11: A read of offset 0x18 returns `top_result_i`.
- R12: Mask registers (0x04 and 0xA0) and steer registers (0x08 and 0xA4) read back the full 32-bit word last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| irq_lines_i | input | 40 | Level-sensitive interrupt lines |
| halted_i | input | 1 | High while the core is halted |
| bus_addr_i | input | 8 | Byte address for reads and writes |
| bus_wr_i | input | 1 | Write strobe |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Combinational read data for `bus_addr_i` |
| top_result_i | input | 32 | Result from the external priority lookup |
| fiq_o | output | 1 | Fast-interrupt request |
| irq_o | output | 1 | Normal-interrupt request |
| wake_o | output | 1 | Wake request to a halted core |

## Verification
Results arrive on fixed schedules:

- Register writes land on the strobed edge and read back at once, since the read path is combinational.
- `fiq_o`, `irq_o` and `wake_o` follow a mask, steer, control or halt change one edge later.
- The outputs follow a line change two edges later, because the pending stage sits in between.

The bench drives inputs and samples outputs on the falling edge. It checks the old output value on the intermediate edge and the new value on the edge where the change is due, so an extra or a missing register stage is caught.

// File: rtl/irqs_pkg.sv
package irqs_pkg;
    localparam int unsigned WORD_W = 32;
    localparam int unsigned ADDR_W = 8;
    localparam int unsigned PRIO_ID_W = 6;

    // bank-relative offsets; bank 0 at 0x00, bank 1 at 0x9C
    localparam logic [ADDR_W-1:0] REL_IRQV  = 8'h00;
    localparam logic [ADDR_W-1:0] REL_MASK  = 8'h04;
    localparam logic [ADDR_W-1:0] REL_STEER = 8'h08;
    localparam logic [ADDR_W-1:0] REL_FIQV  = 8'h0C;
    localparam logic [ADDR_W-1:0] REL_PEND  = 8'h10;
    localparam logic [ADDR_W-1:0] OFF_CTL   = 8'h14;
    localparam logic [ADDR_W-1:0] OFF_TOP   = 8'h18;
    localparam logic [ADDR_W-1:0] OFF_PRIO_LO_FIRST = 8'h1C;
    localparam logic [ADDR_W-1:0] OFF_PRIO_LO_LAST  = 8'h98;
    localparam logic [ADDR_W-1:0] OFF_PRIO_HI_FIRST = 8'hB0;

    typedef enum logic [1:0] {
        ST_RUN       = 2'd0,
        ST_HALT_WAIT = 2'd1,
        ST_WAKE      = 2'd2
    } wake_state_e;

    function automatic logic [ADDR_W-1:0] bank_base(input int b);
        return (b == 0) ? 8'h00 : 8'h9C;
    endfunction
endpackage

// File: rtl/irqs_bank.sv
module irqs_bank #(
    parameter int unsigned W    = 32,
    parameter int unsigned LIVE = 32
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] line_i,
    input  logic         wr_mask_i,
    input  logic         wr_steer_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] pend_o,
    output logic [W-1:0] mask_o,
    output logic [W-1:0] steer_o
);
    logic [W-1:0] live_mask;

    for (genvar b = 0; b < W; b++) begin : g_live
        assign live_mask[b] = (b < LIVE) ? 1'b1 : 1'b0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            pend_o  <= '0;
            mask_o  <= '0;
            steer_o <= '0;
        end else begin
            pend_o <= line_i & live_mask;
            if (wr_mask_i)  mask_o  <= wdata_i;
            if (wr_steer_i) steer_o <= wdata_i;
        end
    end
endmodule

// File: rtl/irqs_prio.sv
module irqs_prio #(
    parameter int unsigned N   = 40,
    parameter int unsigned W   = 32,
    parameter int unsigned IDW = 6,
    localparam int unsigned IXW = $clog2(N)
) (
    input  logic           clk_i,
    input  logic           rst_ni,
    input  logic           wr_i,
    input  logic [IXW-1:0] idx_i,
    input  logic [W-1:0]   wdata_i,
    output logic [W-1:0]   rdata_o
);
    logic           en_q [N];
    logic [IDW-1:0] id_q [N];

    for (genvar i = 0; i < N; i++) begin : g_ent
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                en_q[i] <= 1'b0;
                id_q[i] <= '0;
            end else if (wr_i && (int'(idx_i) == i)) begin
                en_q[i] <= wdata_i[W-1];
                id_q[i] <= wdata_i[IDW-1:0];
            end
        end
    end

    always_comb begin
        rdata_o = '0;
        if (int'(idx_i) < int'(N)) begin
            rdata_o[W-1]     = en_q[idx_i];
            rdata_o[IDW-1:0] = id_q[idx_i];
        end
    end
endmodule

// File: rtl/irqs_wake_fsm.sv
module irqs_wake_fsm
    import irqs_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic halted_i,
    input  logic cause_i,
    output logic wake_o
);
    wake_state_e state_q, state_d;

    always_comb begin
        unique case (state_q)
            ST_RUN, ST_HALT_WAIT, ST_WAKE: begin
                if (!halted_i)    state_d = ST_RUN;       // go_run
                else if (cause_i) state_d = ST_WAKE;      // go_wake
                else              state_d = ST_HALT_WAIT; // go_wait
            end
            default: state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= ST_RUN;
        else         state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            ST_WAKE: wake_o = 1'b1;
            default: wake_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/irq_steer_ctrl.sv
module irq_steer_ctrl
    import irqs_pkg::*;
#(
    parameter int unsigned NSRC = 40
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [NSRC-1:0]   irq_lines_i,
    input  logic              halted_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic              bus_wr_i,
    input  logic [WORD_W-1:0] bus_wdata_i,
    output logic [WORD_W-1:0] bus_rdata_o,
    input  logic [WORD_W-1:0] top_result_i,
    output logic              fiq_o,
    output logic              irq_o,
    output logic              wake_o
);
    localparam int unsigned W     = WORD_W;
    localparam int unsigned NBANK = (NSRC + W - 1) / W;
    localparam int unsigned PIW   = $clog2(NSRC);
    localparam logic [ADDR_W-1:0] PRIO_HI_LAST = ADDR_W'(int'(OFF_PRIO_HI_FIRST) + 4 * (int'(NSRC) - 33));

    logic [NBANK*W-1:0] src_ext;
    logic [W-1:0]       pend_b  [NBANK];
    logic [W-1:0]       mask_b  [NBANK];
    logic [W-1:0]       steer_b [NBANK];
    logic [NBANK*W-1:0] pend_flat, mask_flat, steer_flat;
    logic [NBANK-1:0]   fiq_hit, irq_hit, cause_hit;
    logic               ctl_idle_q;
    logic               fiq_q, irq_q;
    logic               prio_hit;
    logic [PIW-1:0]     prio_idx;
    logic [W-1:0]       prio_rdata;

    assign src_ext = (NBANK*W)'(irq_lines_i);

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        localparam logic [ADDR_W-1:0] BASE = bank_base(b);
        localparam int unsigned LIVE = ((int'(NSRC) - b * int'(W)) >= int'(W)) ? W : (NSRC - b * W);
        irqs_bank #(.W(W), .LIVE(LIVE)) u_bank (
            .clk_i      (clk_i),
            .rst_ni     (rst_ni),
            .line_i     (src_ext[b*W +: W]),
            .wr_mask_i  (bus_wr_i && (bus_addr_i == BASE + REL_MASK)),
            .wr_steer_i (bus_wr_i && (bus_addr_i == BASE + REL_STEER)),
            .wdata_i    (bus_wdata_i),
            .pend_o     (pend_b[b]),
            .mask_o     (mask_b[b]),
            .steer_o    (steer_b[b])
        );
        assign fiq_hit[b]   = |(pend_b[b] & mask_b[b] & steer_b[b]);
        assign irq_hit[b]   = |(pend_b[b] & mask_b[b] & ~steer_b[b]);
        assign cause_hit[b] = |(pend_b[b] & (mask_b[b] | {W{~ctl_idle_q}}));
        assign pend_flat[b*W +: W]  = pend_b[b];
        assign mask_flat[b*W +: W]  = mask_b[b];
        assign steer_flat[b*W +: W] = steer_b[b];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ctl_idle_q <= 1'b0;
            fiq_q      <= 1'b0;
            irq_q      <= 1'b0;
        end else begin
            if (bus_wr_i && bus_addr_i == OFF_CTL) ctl_idle_q <= bus_wdata_i[0];
            fiq_q <= |fiq_hit;
            irq_q <= |irq_hit;
        end
    end

    assign fiq_o = fiq_q;
    assign irq_o = irq_q;

    irqs_wake_fsm u_wake (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .halted_i (halted_i),
        .cause_i  (|cause_hit),
        .wake_o   (wake_o)
    );

    always_comb begin
        prio_hit = 1'b0;
        prio_idx = '0;
        if (bus_addr_i[1:0] == 2'b00) begin
            if (bus_addr_i >= OFF_PRIO_LO_FIRST && bus_addr_i <= OFF_PRIO_LO_LAST) begin
                prio_hit = 1'b1;
                prio_idx = PIW'((bus_addr_i - OFF_PRIO_LO_FIRST) >> 2);
            end else if (bus_addr_i >= OFF_PRIO_HI_FIRST && bus_addr_i <= PRIO_HI_LAST) begin
                prio_hit = 1'b1;
                prio_idx = PIW'(32) + PIW'((bus_addr_i - OFF_PRIO_HI_FIRST) >> 2);
            end
        end
    end

    irqs_prio #(.N(NSRC), .W(W), .IDW(PRIO_ID_W)) u_prio (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .wr_i    (bus_wr_i && prio_hit),
        .idx_i   (prio_idx),
        .wdata_i (bus_wdata_i),
        .rdata_o (prio_rdata)
    );

    always_comb begin
        bus_rdata_o = '0;
        for (int b = 0; b < int'(NBANK); b++) begin
            if (bus_addr_i == bank_base(b) + REL_IRQV)  bus_rdata_o = pend_b[b] & mask_b[b] & ~steer_b[b];
            if (bus_addr_i == bank_base(b) + REL_FIQV)  bus_rdata_o = pend_b[b] & mask_b[b] & steer_b[b];
            if (bus_addr_i == bank_base(b) + REL_MASK)  bus_rdata_o = mask_b[b];
            if (bus_addr_i == bank_base(b) + REL_STEER) bus_rdata_o = steer_b[b];
            if (bus_addr_i == bank_base(b) + REL_PEND)  bus_rdata_o = pend_b[b];
        end
        if (bus_addr_i == OFF_CTL) bus_rdata_o = {{(W-1){1'b0}}, ctl_idle_q};
        if (bus_addr_i == OFF_TOP) bus_rdata_o = top_result_i;
        if (prio_hit)              bus_rdata_o = prio_rdata;
    end
endmodule

// File: rtl/irqs_checks.sv
module irqs_checks #(
    parameter int unsigned NSRC = 40,
    parameter int unsigned FW   = 64
) (
    input logic            clk_i,
    input logic            rst_ni,
    input logic [NSRC-1:0] lines,
    input logic            halted,
    input logic [7:0]      addr,
    input logic [31:0]     rdata,
    input logic            fiq,
    input logic            irq,
    input logic            wake,
    input logic [FW-1:0]   pend,
    input logic [FW-1:0]   mask,
    input logic [FW-1:0]   steer
);
    p_pend_follow_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> pend[NSRC-1:0] == $past(lines));

    p_fiq_route_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> fiq == $past(|(pend & mask & steer)));

    p_irq_route_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> irq == $past(|(pend & mask & ~steer)));

    p_no_wake_running_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !halted |=> !wake);

    p_prio_bits_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (addr[1:0] == 2'b00 && ((addr >= 8'h1C && addr <= 8'h98) || (addr >= 8'hB0 && addr <= 8'hCC)))
        |-> (rdata & 32'h7FFF_FFC0) == 32'h0);

    p_unmapped_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (addr > 8'hCC || addr[1:0] != 2'b00) |-> rdata == 32'h0);
endmodule

bind irq_steer_ctrl irqs_checks #(.NSRC(NSRC), .FW(NBANK*W)) u_chk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lines  (irq_lines_i),
    .halted (halted_i),
    .addr   (bus_addr_i),
    .rdata  (bus_rdata_o),
    .fiq    (fiq_o),
    .irq    (irq_o),
    .wake   (wake_o),
    .pend   (pend_flat),
    .mask   (mask_flat),
    .steer  (steer_flat)
);

// File: tb/sim_irq_steer_ctrl.sv
module sim_irq_steer_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [39:0] lines = '0;
    logic        halted = 1'b0;
    logic [7:0]  addr = '0;
    logic        wr = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [31:0] topres = 32'hCAFE_0123;
    logic        fiq, irq, wake;
    int          n_chk = 0;
    int          n_err = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    irq_steer_ctrl u0 (
        .clk_i(clk), .rst_ni(rst_n), .irq_lines_i(lines), .halted_i(halted),
        .bus_addr_i(addr), .bus_wr_i(wr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
        .top_result_i(topres), .fiq_o(fiq), .irq_o(irq), .wake_o(wake)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wreg(input logic [7:0] a, input logic [31:0] d);
        addr = a; wdata = d; wr = 1'b1;
        tick();
        wr = 1'b0;
    endtask

    task automatic rchk(input string req, input logic [7:0] a, input logic [31:0] exp);
        addr = a;
        #1;
        chk(req, rdata, exp);
    endtask

    task automatic t_reset();
        rchk("R9 mask0", 8'h04, 0);  rchk("R9 steer0", 8'h08, 0);
        rchk("R9 pend0", 8'h10, 0);  rchk("R9 mask1", 8'hA0, 0);
        rchk("R9 steer1", 8'hA4, 0); rchk("R9 pend1", 8'hAC, 0);
        rchk("R9 ctl", 8'h14, 0);    rchk("R9 prio0", 8'h1C, 0);
        rchk("R9 prio39", 8'hCC, 0);
        chk("R9 fiq", 32'(fiq), 0); chk("R9 irq", 32'(irq), 0); chk("R9 wake", 32'(wake), 0);
    endtask

    task automatic t_bank_map();
        lines[5] = 1'b1; lines[35] = 1'b1;
        tick();
        rchk("R1 bank0 bit5", 8'h10, 32'h0000_0020);
        rchk("R1 bank1 src35", 8'hAC, 32'h0000_0008);
        lines = '0;
        tick();
        rchk("R2 no latch bank0", 8'h10, 0);
        rchk("R2 no latch bank1", 8'hAC, 0);
    endtask

    task automatic t_steer();
        wreg(8'h04, 32'hFFFF_FFFF);
        wreg(8'h08, 32'h0000_0010);
        rchk("R12 mask readback", 8'h04, 32'hFFFF_FFFF);
        rchk("R12 steer readback", 8'h08, 32'h0000_0010);
        lines[4] = 1'b1;
        tick();
        chk("R3 fiq not yet", 32'(fiq), 0);
        tick();
        chk("R3 fiq set", 32'(fiq), 1);
        chk("R4 irq clear", 32'(irq), 0);
        rchk("R5 fiq view", 8'h0C, 32'h10);
        rchk("R5 irq view", 8'h00, 32'h0);
        lines[7] = 1'b1;
        tick(); tick();
        chk("R4 irq set", 32'(irq), 1);
        wreg(8'hA0, 32'h0000_0008);
        lines[35] = 1'b1;
        tick();
        rchk("R5 irq view bank1", 8'h9C, 32'h8);
        rchk("R5 fiq view bank1", 8'hA8, 32'h0);
        wreg(8'h08, 32'h0);
        chk("R3 fiq old value at write edge", 32'(fiq), 1);
        tick();
        chk("R3 fiq cleared after steer write", 32'(fiq), 0);
        lines = '0;
        wreg(8'h04, 0); wreg(8'hA0, 0);
        tick(); tick();
        chk("R4 irq cleared", 32'(irq), 0);
    endtask

    task automatic t_views_ro();
        wreg(8'h04, 32'h3);
        wreg(8'h08, 32'h2);
        lines[0] = 1'b1; lines[1] = 1'b1;
        tick();
        wreg(8'h00, 32'hFFFF);
        wreg(8'h0C, 32'h0);
        wreg(8'h10, 32'hFFFF);
        wreg(8'hAC, 32'hFF);
        rchk("R5 mask untouched", 8'h04, 32'h3);
        rchk("R5 steer untouched", 8'h08, 32'h2);
        rchk("R5 irq view", 8'h00, 32'h1);
        rchk("R5 fiq view", 8'h0C, 32'h2);
        rchk("R5 pend untouched", 8'h10, 32'h3);
        rchk("R5 pend1 untouched", 8'hAC, 32'h0);
        lines = '0;
        wreg(8'h04, 0); wreg(8'h08, 0);
        tick();
    endtask

    task automatic t_wake();
        lines[36] = 1'b1;
        tick(); tick();
        chk("R7 no wake while running", 32'(wake), 0);
        halted = 1'b1;
        tick();
        chk("R6 masked source wakes in mode 0", 32'(wake), 1);
        wreg(8'h14, 32'hFFFF_FFFF);
        chk("R6 wake holds at ctl write edge", 32'(wake), 1);
        tick();
        chk("R6 masked source ignored in mode 1", 32'(wake), 0);
        rchk("R6 ctl reads 1", 8'h14, 32'h1);
        wreg(8'hA0, 32'h10);
        tick();
        chk("R6 enabled source wakes in mode 1", 32'(wake), 1);
        halted = 1'b0;
        tick();
        chk("R7 wake drops when running", 32'(wake), 0);
        wreg(8'h14, 0);
        rchk("R6 ctl reads 0", 8'h14, 32'h0);
        lines = '0;
        wreg(8'hA0, 0);
        tick();
    endtask

    task automatic t_prio();
        wreg(8'h1C, 32'hFFFF_FFFF);
        rchk("R8 prio0 kept bits", 8'h1C, 32'h8000_003F);
        wreg(8'hCC, 32'h1234_5678);
        rchk("R8 prio39 kept bits", 8'hCC, 32'h0000_0038);
        wreg(8'hB0, 32'h8000_0027);
        rchk("R8 prio32", 8'hB0, 32'h8000_0027);
        rchk("R8 prio1 untouched", 8'h20, 32'h0);
    endtask

    task automatic t_unmapped();
        wreg(8'hD0, 32'hFFFF_FFFF);
        rchk("R10 read above map", 8'hD0, 0);
        wreg(8'h05, 32'hFFFF_FFFF);
        rchk("R10 misaligned read", 8'h05, 0);
        rchk("R10 misaligned write ignored", 8'h04, 0);
        rchk("R10 prio untouched", 8'h1C, 32'h8000_003F);
        rchk("R11 top result", 8'h18, 32'hCAFE_0123);
        topres = 32'h0BAD_F00D;
        rchk("R11 top result follows", 8'h18, 32'h0BAD_F00D);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        tick();
        t_bank_map();
        t_steer();
        t_views_ro();
        t_wake();
        t_prio();
        t_unmapped();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule